// File: doc/BRIEF.md
# Seven-Input Column Counter

This block counts the ones in a column of seven bits that all carry the same weight. It returns the count as a three-bit binary number from 0 to 7. It is the column stage of a bit-array reduction: each column of the array goes into one counter. The three result bits have adjacent weights, so they can be placed straight back into the next, shorter array. A parameter sets how many independent columns sit side by side, and each column has its own counter.

Each counter is a gate network, not a table. The seven bits are split into a low group of three bits and a high group of four bits:
- A full adder counts the low group and gives a two-bit partial count.
- A dedicated four-input count network counts the high group and gives a three-bit partial count. Its top bit is set only when all four bits are one.
- A small generate/propagate adder merges the two partial counts.

The merged counts pass through one output register, which has a synchronous active-low reset. The result therefore appears one clock after the column bits are sampled.

Top module: `col_count7`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, every column count is cleared to 0. The counts read 0 in the cycle after reset is released.
- R2: Column k takes its input from bits [7k+6:7k] of `col_bits_i` and drives its count on bits [3k+2:3k] of `col_cnt_o`. After a rising edge with `rst_n` high, the count equals the number of ones among that column's seven bits at that edge.
- R3: A column whose seven bits are all one reports 7 (binary 111). No overflow occurs.
- R4: A column whose seven bits are all zero reports 0.
- R5: A column's count does not depend on the bits of any other column.
- R6: When only the four upper bits of a column (positions 6..3 within the column) are set, the count equals the number of them set, from 0 to 4. If all four are set, the result is 4 (binary 100).
- R7: When only the three lower bits of a column (positions 2..0) are set, the count equals the number of them set, from 0 to 3.
- R8: Each count is registered. A change on the inputs reaches `col_cnt_o` exactly one rising clock edge later, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counts are registered on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the count register |
| col_bits_i | input | 7*COLS | Seven equally weighted bits per column; column k uses bits [7k+6:7k] |
| col_cnt_o | output | 3*COLS | Registered count of ones per column; column k on bits [3k+2:3k] |

## Verification
On every clock, the assertions compare each column's registered count with the population count of that column's bits one edge earlier. They also check the all-zero and all-one columns and the cleared value just after reset. The bench scenarios cover the rest:
- all 128 input patterns on each column;
- the upper-group and lower-group patterns that exercise each partial count alone;
- column independence, by sweeping one column while its neighbour is held;
- the exact cycle in which a new count first appears.

// File: rtl/col_count7_pkg.sv
// Package: col_count7_pkg
// Shared sizes and types for the seven-input column counter.
// Assumes the split is fixed at three low bits and four high bits.
package col_count7_pkg;
    localparam int COL_IN   = 7;   // bits per column
    localparam int CNT_W    = 3;   // bits of a column count
    localparam int LO_W     = 3;   // low group width
    localparam int HI_W     = COL_IN - LO_W;   // high group width
    localparam int LO_CNT_W = 2;   // width of low group count (max 3)
    localparam int HI_CNT_W = 3;   // width of high group count (max 4)

    typedef logic [COL_IN-1:0]   col_bits_t;
    typedef logic [CNT_W-1:0]    col_cnt_t;
    typedef logic [LO_CNT_W-1:0] lo_cnt_t;
    typedef logic [HI_CNT_W-1:0] hi_cnt_t;
endpackage

// File: rtl/cc7_lo_fa.sv
// Module: cc7_lo_fa
// Counts the ones in a three-bit group with a single full adder.
// Output: {carry, sum}, a value from 0 to 3. Purely combinational.
module cc7_lo_fa
    import col_count7_pkg::*;
(
    input  logic [LO_W-1:0] grp_i,
    output lo_cnt_t         cnt_o
);
    // full adder: sum is the parity, carry is the majority
    always_comb begin
        cnt_o[0] = grp_i[0] ^ grp_i[1] ^ grp_i[2];
        cnt_o[1] = (grp_i[0] & grp_i[1]) | (grp_i[0] & grp_i[2]) | (grp_i[1] & grp_i[2]);
    end
endmodule

// File: rtl/cc7_hi_cnt4.sv
// Module: cc7_hi_cnt4
// Counts the ones in a four-bit group and gives a value from 0 to 4.
// Built from two half-adder pairs. The top bit can only be set when all
// four inputs are one, so the lower two bits are then zero. Combinational.
module cc7_hi_cnt4
    import col_count7_pkg::*;
(
    input  logic [HI_W-1:0] grp_i,
    output hi_cnt_t         cnt_o
);
    logic h_lo, c_lo, h_hi, c_hi, k_mid;

    // half adders on each pair of inputs
    always_comb begin
        h_lo = grp_i[0] ^ grp_i[1];
        c_lo = grp_i[0] & grp_i[1];
        h_hi = grp_i[2] ^ grp_i[3];
        c_hi = grp_i[2] & grp_i[3];
    end

    // combine the pair sums: units, twos, fours
    always_comb begin
        k_mid    = h_lo & h_hi;
        cnt_o[0] = h_lo ^ h_hi;
        cnt_o[1] = c_lo ^ c_hi ^ k_mid;
        cnt_o[2] = (c_lo & c_hi) | ((c_lo ^ c_hi) & k_mid);
    end
endmodule

// File: rtl/cc7_merge.sv
// Module: cc7_merge
// Adds the low group count (0..3) and the high group count (0..4).
// The carry into bit 2 uses lookahead: G1 | (P1 & G0).
// Assumes a sum no larger than 7, so no carry leaves bit 2.
module cc7_merge
    import col_count7_pkg::*;
(
    input  lo_cnt_t  a_i,
    input  hi_cnt_t  b_i,
    output col_cnt_t sum_o
);
    logic g0, p1, g1, c2;

    // generate / propagate terms of the two low positions
    always_comb begin
        g0 = a_i[0] & b_i[0];
        p1 = a_i[1] ^ b_i[1];
        g1 = a_i[1] & b_i[1];
        c2 = g1 | (p1 & g0);
    end

    // sum bits; b_i[2] and c2 are never both set
    always_comb begin
        sum_o[0] = a_i[0] ^ b_i[0];
        sum_o[1] = p1 ^ g0;
        sum_o[2] = b_i[2] ^ c2;
    end
endmodule

// File: rtl/cc7_core.sv
// Module: cc7_core
// One combinational seven-input counter: splits the column into bits 2..0
// and bits 6..3, counts each group and merges the partial counts.
module cc7_core
    import col_count7_pkg::*;
(
    input  col_bits_t bits_i,
    output col_cnt_t  cnt_o
);
    lo_cnt_t lo_cnt;
    hi_cnt_t hi_cnt;

    cc7_lo_fa u_lo (
        .grp_i (bits_i[LO_W-1:0]),
        .cnt_o (lo_cnt)
    );

    cc7_hi_cnt4 u_hi (
        .grp_i (bits_i[COL_IN-1:LO_W]),
        .cnt_o (hi_cnt)
    );

    cc7_merge u_mrg (
        .a_i   (lo_cnt),
        .b_i   (hi_cnt),
        .sum_o (cnt_o)
    );
endmodule

// File: rtl/col_count7.sv
// Module: col_count7
// Top: COLS independent seven-input counters side by side. Each count
// goes through one output register with a synchronous active-low reset.
// Assumes all bits of one column carry equal weight.
module col_count7
    import col_count7_pkg::*;
#(
    parameter int COLS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [COLS*COL_IN-1:0] col_bits_i,
    output logic [COLS*CNT_W-1:0]  col_cnt_o
);
    localparam int OUT_W = COLS * CNT_W;

    logic [OUT_W-1:0] cnt_next;

    for (genvar k = 0; k < COLS; k++) begin : g_col
        cc7_core u_core (
            .bits_i (col_bits_i[k*COL_IN +: COL_IN]),
            .cnt_o  (cnt_next[k*CNT_W +: CNT_W])
        );
    end

    // output register, cleared by synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) col_cnt_o <= '0;
        else        col_cnt_o <= cnt_next;
    end
endmodule

// File: rtl/col_count7_chk.sv
// Module: col_count7_chk
// Checker bound to col_count7. It compares each registered column count
// with the population count of the bits one edge earlier.
module col_count7_chk
    import col_count7_pkg::*;
#(
    parameter int COLS = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [COLS*COL_IN-1:0] col_bits_i,
    input logic [COLS*CNT_W-1:0]  col_cnt_o
);
    // R1
    reset_zero_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> col_cnt_o == '0);

    for (genvar k = 0; k < COLS; k++) begin : g_chk
        // R2
        count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> col_cnt_o[k*CNT_W +: CNT_W] ==
                CNT_W'($countones($past(col_bits_i[k*COL_IN +: COL_IN]))));
        // R3
        all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(col_bits_i[k*COL_IN +: COL_IN]) == '1)
                |-> col_cnt_o[k*CNT_W +: CNT_W] == CNT_W'(7));
        // R4
        all_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(col_bits_i[k*COL_IN +: COL_IN]) == '0)
                |-> col_cnt_o[k*CNT_W +: CNT_W] == '0);
    end
endmodule

bind col_count7 col_count7_chk #(.COLS(COLS)) u_col_count7_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .col_bits_i (col_bits_i),
    .col_cnt_o  (col_cnt_o)
);

// File: tb/tb_col_count7.sv
// Bench for col_count7: directed tasks, each checking its own results.
module tb_col_count7;
    localparam int COLS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] col_bits_i = '0;
    logic [5:0]  col_cnt_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    col_count7 #(.COLS(COLS)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .col_bits_i (col_bits_i),
        .col_cnt_o  (col_cnt_o)
    );

    always #2 clk = ~clk;   // 250 MHz

    function automatic int pop7(input logic [6:0] v);
        int c = 0;
        for (int i = 0; i < 7; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic check(input string req, input int col, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s col%0d: actual %0d expected %0d", req, col, act, exp);
        end
    endtask

    // drive both columns at a falling edge, then sample just after the next rising edge
    task automatic apply(input logic [6:0] c0, input logic [6:0] c1);
        @(negedge clk);
        col_bits_i = {c1, c0};
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        col_bits_i = '1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 0, int'(col_cnt_o[2:0]), 0);
        check("R1", 1, int'(col_cnt_o[5:3]), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_exhaustive();
        for (int v = 0; v < 128; v++) begin
            apply(7'(v), ~7'(v));
            check("R2", 0, int'(col_cnt_o[2:0]), pop7(7'(v)));
            check("R2", 1, int'(col_cnt_o[5:3]), pop7(~7'(v)));
        end
    endtask

    task automatic t_extremes();
        apply(7'h7F, 7'h00);
        check("R3", 0, int'(col_cnt_o[2:0]), 7);
        check("R4", 1, int'(col_cnt_o[5:3]), 0);
        apply(7'h00, 7'h7F);
        check("R4", 0, int'(col_cnt_o[2:0]), 0);
        check("R3", 1, int'(col_cnt_o[5:3]), 7);
    endtask

    task automatic t_upper_group();
        for (int v = 0; v < 16; v++) begin
            apply({4'(v), 3'b000}, {4'(v), 3'b000});
            check("R6", 0, int'(col_cnt_o[2:0]), pop7({4'(v), 3'b000}));
            check("R6", 1, int'(col_cnt_o[5:3]), pop7({4'(v), 3'b000}));
        end
        apply(7'b1111000, 7'b1111111);
        check("R6", 0, int'(col_cnt_o[2:0]), 4);
    endtask

    task automatic t_lower_group();
        for (int v = 0; v < 8; v++) begin
            apply({4'b0000, 3'(v)}, {4'b0000, 3'(7 - v)});
            check("R7", 0, int'(col_cnt_o[2:0]), pop7({4'b0000, 3'(v)}));
            check("R7", 1, int'(col_cnt_o[5:3]), pop7({4'b0000, 3'(7 - v)}));
        end
    endtask

    task automatic t_isolation();
        for (int v = 0; v < 128; v++) begin
            apply(7'b1010110, 7'(v));
            check("R5", 0, int'(col_cnt_o[2:0]), 4);
        end
        for (int v = 0; v < 128; v += 5) begin
            apply(7'(v), 7'b0000001);
            check("R5", 1, int'(col_cnt_o[5:3]), 1);
        end
    endtask

    task automatic t_latency();
        apply(7'h00, 7'h00);
        @(negedge clk);
        col_bits_i = {7'h7F, 7'h3F};
        #1;
        check("R8", 0, int'(col_cnt_o[2:0]), 0);   // not yet registered
        check("R8", 1, int'(col_cnt_o[5:3]), 0);
        @(posedge clk);
        #1;
        check("R8", 0, int'(col_cnt_o[2:0]), 6);
        check("R8", 1, int'(col_cnt_o[5:3]), 7);
    endtask

    initial begin
        t_reset();
        t_exhaustive();
        t_extremes();
        t_upper_group();
        t_lower_group();
        t_isolation();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule